// File: doc/BRIEF.md
# Secure Low-Power Real-Time Clock with Alarm

This block keeps wall-clock time in a slow, always-on clock domain while software reaches it through a 32-bit register bus clocked by a faster bus clock. It holds a 32-bit seconds count, a sub-second tick count, a 32-bit alarm compare value, a control word, a status word and a guard word. The guard word must hold a fixed key pattern. The seconds count and the alarm are plain unsigned second counts, and the seconds count can be written to set the time.

Counting is held off by a three-state security sequencer. After reset the sequencer sits in an initial state. Software loads the guard key and requests an exit, which moves the block to a non-valid state. A second request, which also enables low-power counting, moves it to the valid state. Only then do the counters advance. When the seconds count steps onto the alarm value, an alarm flag sets. The interrupt line follows that flag while the alarm interrupt is enabled. Software clears the flag by writing 1 to it.

Every bus write is carried into the slow domain by a toggle handshake, so it lands a few slow-clock periods after the bus cycle. A second write issued while the first is still in flight is dropped. Software paces its writes by watching the sub-second count advance. Register reads return copies of the slow-domain state, passed through a two-flop stage into the bus domain.

Top module: `rtcs_top`

## Requirements
- R1: After reset every register reads 0, the interrupt output is low and the sequencer is in its initial state.
- R2: Registers sit at byte offsets 0x00 seconds, 0x04 sub-second, 0x08 alarm, 0x10 control, 0x14 status and 0x18 guard. Alarm, guard and control read back what was written. Control keeps only bits 3, 4, 7, 11, 14 and 15; its other bits read 0.
- R3: The sub-second and seconds counters hold their values unless the sequencer is valid and control bit 3 (count enable) is set.
- R4: With the guard equal to 0x41736166 and control bits 15 and 11 set, the sequencer leaves the initial state and status bit 15 reads 1. With control bits 15, 14, 11 and 3 all set, it then reaches the valid state and status bit 14 reads 1. The sequencer never moves backwards.
- R5: While the guard does not hold 0x41736166, an init-exit request in the control word has no effect and the status reads 0.
- R6: While counting, the sub-second counter advances on every slow-clock edge and carries into the seconds counter every 2^TICK_W ticks. A write to offset 0x00 loads the seconds counter.
- R7: Status bit 3 (alarm flag) sets on the slow edge where the seconds counter advances to a value equal to the alarm register.
- R8: Writing 1 to status bit 3 clears the alarm flag, and writing 0 leaves it set. Status bits 15 and 14 reflect the sequencer state and are not changed by writes.
- R9: The interrupt output is high exactly while the alarm flag and control bit 7 (alarm interrupt enable) are both set.
- R10: A bus write takes effect only after it has been carried into the slow domain. A write issued while an earlier write is still in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Bus-side clock |
| clk_slow | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, from the bus-domain copy |
| irq_o | output | 1 | Alarm interrupt, driven from the slow domain |

## Verification
On every slow cycle the assertions check four things. The counters stay frozen outside the valid counting condition. The sequencer moves only forward, and it does not leave its initial state while the guard key is absent. Each rise of the alarm flag coincides with the seconds value equal to the alarm value. Each transferred write shows up as a single-cycle strobe.

The bench scenarios show the end-to-end behaviour of the block: readback masking, the two-step unlock seen in the status word, carry timing between the sub-second and seconds counts, and the write-1-to-clear and interrupt-enable interplay. They also show the loss of a write issued while another is still in flight, which is visible only across both clock domains.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
  localparam int unsigned REG_AW = 5;

  localparam logic [REG_AW-1:0] A_SECS  = 5'h00;
  localparam logic [REG_AW-1:0] A_SUB   = 5'h04;
  localparam logic [REG_AW-1:0] A_ALARM = 5'h08;
  localparam logic [REG_AW-1:0] A_CTRL  = 5'h10;
  localparam logic [REG_AW-1:0] A_STAT  = 5'h14;
  localparam logic [REG_AW-1:0] A_GUARD = 5'h18;

  localparam int CB_COUNT = 3;
  localparam int CB_WAKE  = 4;
  localparam int CB_AIE   = 7;
  localparam int CB_NSEC  = 11;
  localparam int CB_NVX   = 14;
  localparam int CB_INX   = 15;

  localparam int SB_ALM = 3;
  localparam int SB_NVX = 14;
  localparam int SB_INX = 15;

  localparam logic [31:0] CTRL_MASK = (32'd1 << CB_COUNT) | (32'd1 << CB_WAKE) |
                                      (32'd1 << CB_AIE)   | (32'd1 << CB_NSEC) |
                                      (32'd1 << CB_NVX)   | (32'd1 << CB_INX);

  localparam logic [31:0] GUARD_KEY = 32'h4173_6166;

  typedef enum logic [1:0] {
    ST_INIT     = 2'd0,
    ST_NONVALID = 2'd1,
    ST_VALID    = 2'd2
  } sec_state_e;
endpackage

// File: rtl/rtcs_rst_sync.sv
module rtcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/rtcs_wr_xfer.sv
module rtcs_wr_xfer #(
  parameter int AW   = 5,
  parameter int DW   = 32,
  parameter int SYNC = 2
) (
  input  logic          clk_bus,
  input  logic          rst_bus_n,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          clk_slow,
  input  logic          rst_slow_n,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  // bus side
  logic          req_q, req_nx;
  logic [AW-1:0] haddr_q;
  logic [DW-1:0] hdata_q;
  logic [SYNC-1:0] ack_sync_q;
  logic          pend, accept;
  // slow side
  logic [SYNC:0] req_sync_q;
  logic          ack_slow;

  assign pend   = req_q ^ ack_sync_q[SYNC-1];
  assign accept = wr_i && !pend;

  always_comb begin
    req_nx = req_q;
    if (accept) req_nx = ~req_q;
  end

  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n) begin
      req_q      <= 1'b0;
      haddr_q    <= '0;
      hdata_q    <= '0;
      ack_sync_q <= '0;
    end else begin
      req_q      <= req_nx;
      ack_sync_q <= {ack_sync_q[SYNC-2:0], ack_slow};
      if (accept) begin
        haddr_q <= addr_i;
        hdata_q <= data_i;
      end
    end
  end

  always_ff @(posedge clk_slow or negedge rst_slow_n) begin
    if (!rst_slow_n) req_sync_q <= '0;
    else             req_sync_q <= {req_sync_q[SYNC-1:0], req_q};
  end

  assign ack_slow  = req_sync_q[SYNC];
  assign wr_stb_o  = req_sync_q[SYNC] ^ req_sync_q[SYNC-1];
  assign wr_addr_o = haddr_q;
  assign wr_data_o = hdata_q;
endmodule

// File: rtl/rtcs_rd_sync.sv
module rtcs_rd_sync #(
  parameter int W    = 32,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [SYNC-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < SYNC; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[SYNC-1];
endmodule

// File: rtl/rtcs_core.sv
module rtcs_core
  import rtcs_pkg::*;
#(
  parameter int TICK_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       secs_o,
  output logic [TICK_W-1:0] tick_o,
  output logic [31:0]       alarm_o,
  output logic [31:0]       ctrl_o,
  output logic [31:0]       stat_o,
  output logic [31:0]       guard_o,
  output sec_state_e        state_o,
  output logic              alm_flag_o,
  output logic              irq_o
);
  localparam logic [TICK_W-1:0] TICK_ONE = {{(TICK_W-1){1'b0}}, 1'b1};

  logic [31:0]       secs_q, secs_nx, alarm_q, ctrl_q, guard_q;
  logic [TICK_W-1:0] tick_q, tick_nx;
  sec_state_e        state_q, state_nx;
  logic              flag_q, flag_nx;
  logic              wr_secs, wr_alarm, wr_ctrl, wr_stat, wr_guard;
  logic              cnt_en, tick_wrap, alm_hit, secs_ld;
  logic [31:0]       alarm_nx;

  always_comb begin
    wr_secs  = wr_stb_i && (wr_addr_i == A_SECS);
    wr_alarm = wr_stb_i && (wr_addr_i == A_ALARM);
    wr_ctrl  = wr_stb_i && (wr_addr_i == A_CTRL);
    wr_stat  = wr_stb_i && (wr_addr_i == A_STAT);
    wr_guard = wr_stb_i && (wr_addr_i == A_GUARD);

    cnt_en    = (state_q == ST_VALID) && ctrl_q[CB_COUNT];
    tick_wrap = cnt_en && (&tick_q);
    tick_nx   = tick_q + TICK_ONE;
    secs_ld   = wr_secs || tick_wrap;
    secs_nx   = wr_secs ? wr_data_i : (secs_q + 32'd1);
    alarm_nx  = wr_alarm ? wr_data_i : alarm_q;

    alm_hit = tick_wrap && !wr_secs && ((secs_q + 32'd1) == alarm_nx);
    flag_nx = alm_hit || (flag_q && !(wr_stat && wr_data_i[SB_ALM]));

    state_nx = state_q;
    case (state_q)
      ST_INIT:
        if (ctrl_q[CB_INX] && ctrl_q[CB_NSEC] && (guard_q == GUARD_KEY))
          state_nx = ST_NONVALID;
      ST_NONVALID:
        if (ctrl_q[CB_INX] && ctrl_q[CB_NVX] && ctrl_q[CB_NSEC] && ctrl_q[CB_COUNT])
          state_nx = ST_VALID;
      default: state_nx = ST_VALID;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q  <= '0;
      tick_q  <= '0;
      alarm_q <= '0;
      ctrl_q  <= '0;
      guard_q <= '0;
      flag_q  <= 1'b0;
      state_q <= ST_INIT;
    end else begin
      if (cnt_en)   tick_q  <= tick_nx;
      if (secs_ld)  secs_q  <= secs_nx;
      if (wr_alarm) alarm_q <= alarm_nx;
      if (wr_ctrl)  ctrl_q  <= wr_data_i & CTRL_MASK;
      if (wr_guard) guard_q <= wr_data_i;
      flag_q  <= flag_nx;
      state_q <= state_nx;
    end
  end

  always_comb begin
    stat_o         = '0;
    stat_o[SB_ALM] = flag_q;
    stat_o[SB_INX] = (state_q != ST_INIT);
    stat_o[SB_NVX] = (state_q == ST_VALID);
  end

  assign secs_o     = secs_q;
  assign tick_o     = tick_q;
  assign alarm_o    = alarm_q;
  assign ctrl_o     = ctrl_q;
  assign guard_o    = guard_q;
  assign state_o    = state_q;
  assign alm_flag_o = flag_q;
  assign irq_o      = flag_q && ctrl_q[CB_AIE];
endmodule

// File: rtl/rtcs_top.sv
module rtcs_top
  import rtcs_pkg::*;
#(
  parameter int TICK_W = 15,
  parameter int SYNC   = 2
) (
  input  logic              clk_bus,
  input  logic              clk_slow,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);
  localparam int PAD = 32 - TICK_W;
  localparam int RDW = 5 * 32 + TICK_W;

  logic              rst_bus_n, rst_slow_n;
  logic              wr_stb;
  logic [REG_AW-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic [31:0]       secs_s, alarm_s, ctrl_s, stat_s, guard_s;
  logic [TICK_W-1:0] tick_s;
  sec_state_e        state_s;
  logic              flag_s;
  logic [RDW-1:0]    rd_slow, rd_bus;

  rtcs_rst_sync #(.STAGES(SYNC)) u_rst_bus (
    .clk(clk_bus), .arst_n(rst_n), .rst_n_o(rst_bus_n));

  rtcs_rst_sync #(.STAGES(SYNC)) u_rst_slow (
    .clk(clk_slow), .arst_n(rst_n), .rst_n_o(rst_slow_n));

  rtcs_wr_xfer #(.AW(REG_AW), .DW(32), .SYNC(SYNC)) u_wr (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .wr_i(bus_wr),
    .addr_i(bus_addr), .data_i(bus_wdata),
    .clk_slow(clk_slow), .rst_slow_n(rst_slow_n),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data));

  rtcs_core #(.TICK_W(TICK_W)) u_core (
    .clk(clk_slow), .rst_n(rst_slow_n),
    .wr_stb_i(wr_stb), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .secs_o(secs_s), .tick_o(tick_s), .alarm_o(alarm_s), .ctrl_o(ctrl_s),
    .stat_o(stat_s), .guard_o(guard_s), .state_o(state_s),
    .alm_flag_o(flag_s), .irq_o(irq_o));

  assign rd_slow = {secs_s, alarm_s, ctrl_s, stat_s, guard_s, tick_s};

  rtcs_rd_sync #(.W(RDW), .SYNC(SYNC)) u_rd (
    .clk(clk_bus), .rst_n(rst_bus_n), .d_i(rd_slow), .q_o(rd_bus));

  always_comb begin
    case (bus_addr)
      A_SECS:  bus_rdata = rd_bus[TICK_W+128 +: 32];
      A_SUB:   bus_rdata = {{PAD{1'b0}}, rd_bus[TICK_W-1:0]};
      A_ALARM: bus_rdata = rd_bus[TICK_W+96 +: 32];
      A_CTRL:  bus_rdata = rd_bus[TICK_W+64 +: 32];
      A_STAT:  bus_rdata = rd_bus[TICK_W+32 +: 32];
      A_GUARD: bus_rdata = rd_bus[TICK_W +: 32];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtcs_chk.sv
module rtcs_chk
  import rtcs_pkg::*;
#(
  parameter int TICK_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input sec_state_e        state,
  input logic              cnt_bit,
  input logic [TICK_W-1:0] tick,
  input logic [31:0]       secs,
  input logic [31:0]       alarm,
  input logic [31:0]       guard,
  input logic              flag,
  input logic              wr_stb
);
  // R3
  tick_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((state == ST_VALID) && cnt_bit) |=> $stable(tick));

  // R5
  key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_INIT) && (guard != GUARD_KEY)) |=> (state == ST_INIT));

  // R4
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INIT) |=> (state != ST_VALID));

  // R4
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VALID) |=> (state == ST_VALID));

  // R7
  alarm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (secs == alarm));

  // R10
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

bind rtcs_top rtcs_chk #(.TICK_W(TICK_W)) chk_i (
  .clk(clk_slow), .rst_n(rst_slow_n), .state(state_s),
  .cnt_bit(ctrl_s[rtcs_pkg::CB_COUNT]), .tick(tick_s), .secs(secs_s),
  .alarm(alarm_s), .guard(guard_s), .flag(flag_s), .wr_stb(wr_stb));

// File: tb/rtcs_top_tb_top.sv
module rtcs_top_tb_top;
  import rtcs_pkg::*;

  localparam int BUS_PERIOD  = 10;
  localparam int SLOW_PERIOD = 70;
  localparam int TW          = 3;

  logic        clk_bus, clk_slow, rst_n, bus_wr, irq_o;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  rtcs_top #(.TICK_W(TW), .SYNC(2)) dut_i (
    .clk_bus(clk_bus), .clk_slow(clk_slow), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o));

  initial begin
    clk_bus = 1'b0;
    forever #(BUS_PERIOD/2) clk_bus = ~clk_bus;
  end
  initial begin
    clk_slow = 1'b0;
    #3;
    forever #(SLOW_PERIOD/2) clk_slow = ~clk_slow;
  end

  function automatic void note(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endfunction

  // monitor: pops expected items and compares against the outputs
  always @(negedge clk_bus) begin : mon
    exp_t it;
    logic [31:0] act;
    if (sb_q.size() != 0) begin
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq_o} : bus_rdata;
      note(act == it.exp, it.tag, act, it.exp);
    end
  end

  task automatic expect_reg(input logic [4:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    @(posedge clk_bus); #1;
    bus_addr  = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_bus); @(negedge clk_bus);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    exp_t it;
    @(posedge clk_bus); #1;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_bus); @(negedge clk_bus);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(posedge clk_bus); #1;
    bus_addr = a;
    @(negedge clk_bus);
    v = bus_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk_bus); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk_bus); #1;
    bus_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk_slow);
    repeat (3) @(posedge clk_bus);
  endtask

  initial begin : watchdog
    #(BUS_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : drv
    logic [31:0] v0, v1;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk_slow);
    rst_n = 1'b1;
    repeat (4) @(posedge clk_slow);

    // R1 reset state
    expect_reg(A_SECS,  32'h0, "R1 secs");
    expect_reg(A_SUB,   32'h0, "R1 sub");
    expect_reg(A_CTRL,  32'h0, "R1 ctrl");
    expect_reg(A_STAT,  32'h0, "R1 stat");
    expect_reg(A_GUARD, 32'h0, "R1 guard");
    expect_irq(1'b0, "R1 irq");

    // R5 exit request without key is ignored
    wr(A_CTRL, 32'h0000_8800); settle();
    expect_reg(A_CTRL, 32'h0000_8800, "R2 ctrl");
    expect_reg(A_STAT, 32'h0, "R5 stat");
    repeat (10) @(posedge clk_slow);
    expect_reg(A_SUB, 32'h0, "R3 sub frozen in init");

    // R4 key unlocks first step
    wr(A_GUARD, GUARD_KEY); settle();
    expect_reg(A_GUARD, GUARD_KEY, "R2 guard");
    expect_reg(A_STAT, 32'h0000_8000, "R4 init exit");
    expect_reg(A_SUB, 32'h0, "R3 sub frozen nonvalid");

    // R2 masking and R4 second step
    wr(A_CTRL, 32'hFFFF_FFFF); settle();
    expect_reg(A_CTRL, 32'h0000_C898, "R2 ctrl mask");
    expect_reg(A_STAT, 32'h0000_C000, "R4 valid");
    expect_irq(1'b0, "R9 no flag");
    wr(A_CTRL, 32'h0000_C808); settle();

    // R6 sub-second advances, seconds load and carry
    rd(A_SUB, v0);
    repeat (3) @(posedge clk_slow);
    rd(A_SUB, v1);
    note(v1 != v0, "R6 sub advances", v1, v0);
    wr(A_SECS, 32'd500); settle();
    rd(A_SECS, v0);
    note(v0 >= 32'd500 && v0 <= 32'd501, "R6 secs load", v0, 32'd500);
    repeat (32) @(posedge clk_slow);
    rd(A_SECS, v1);
    note((v1 - v0) >= 32'd3 && (v1 - v0) <= 32'd5, "R6 carry rate", v1 - v0, 32'd4);

    // R7 alarm
    wr(A_CTRL, 32'h0000_C898); settle();
    wr(A_ALARM, 32'd700); settle();
    expect_reg(A_ALARM, 32'd700, "R2 alarm");
    expect_reg(A_STAT, 32'h0000_C000, "R7 no early flag");
    wr(A_SECS, 32'd698);
    for (int i = 0; i < 300 && !irq_o; i++) @(posedge clk_slow);
    expect_irq(1'b1, "R9 irq on flag");
    expect_reg(A_SECS, 32'd700, "R7 secs at alarm");
    expect_reg(A_STAT, 32'h0000_C008, "R7 flag");

    // R8 write-0 leaves the flag, R9 enable gating
    wr(A_STAT, 32'h0); settle();
    expect_reg(A_STAT, 32'h0000_C008, "R8 write0");
    wr(A_CTRL, 32'h0000_C818); settle();
    expect_irq(1'b0, "R9 disabled");
    expect_reg(A_STAT, 32'h0000_C008, "R8 flag kept");
    wr(A_STAT, 32'hFFFF_FFFF); settle();
    expect_reg(A_STAT, 32'h0000_C000, "R8 w1c");
    wr(A_CTRL, 32'h0000_C898); settle();
    expect_irq(1'b0, "R9 cleared");

    // R10 late write and dropped write
    wr(A_ALARM, 32'h1111_1111);
    expect_reg(A_ALARM, 32'd700, "R10 not yet");
    wr(A_ALARM, 32'h2222_2222);
    settle();
    expect_reg(A_ALARM, 32'h1111_1111, "R10 drop");

    // R3 counting disabled in valid state
    wr(A_CTRL, 32'h0000_C890); settle();
    rd(A_SUB, v0);
    rd(A_SECS, v1);
    repeat (20) @(posedge clk_slow);
    expect_reg(A_SUB, v0, "R3 sub hold");
    expect_reg(A_SECS, v1, "R3 secs hold");

    repeat (4) @(posedge clk_bus);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule